// File: doc/BRIEF.md
# Network Controller Interrupt Status Register

This block holds the event flags of a network controller. Hardware sources give one-cycle pulses for events from the transmit path, the receive path, a general timer and the system bus. Each pulse sets a sticky flag at a fixed bit position. Software reads the 32-bit word through a simple register port. It acknowledges events by writing ones to the flags it wants to drop. Bits written with zero are left alone.

Two summary bits are derived from fixed groups of flags. The normal group covers the completion-type events. The abnormal group covers the error-type and stall-type events. Each summary depends only on the flags it currently holds, so it is up to date after every set and every clear. A registered, level-sensitive interrupt line stays high while either summary is set.

A transmit completion raises its flag only when the descriptor that completed asked for an interrupt. On readback, the receive process-state code and a transmit running indication are merged into a field above the summaries.

Top module: `irq_status_reg`

## Requirements
- R1: A pulse on an event input sets its flag on the next clock edge. The positions are: tx_done 0, tx_stop 1, tx_nobuf 2, tx_jabber 3, tx_underflow 5, rx_done 6, rx_nobuf 7, rx_stop 8, rx_wdog 9, timer 11 and bus_err 13. A flag stays set until software clears it.
- R2: Bit 16 (normal summary) reads 1 exactly when at least one of bits 0, 2 or 6 is set.
- R3: Bit 15 (abnormal summary) reads 1 exactly when at least one of bits 1, 3, 5, 7, 8, 9, 11 or 13 is set.
- R4: A write clears every flag whose written data bit is 1. Flags written with 0 keep their value.
- R5: Writes have no direct effect on bits 15 and 16, or on any undefined bit. Undefined bits among 0..16 and bits 23..31 always read 0.
- R6: When a set pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R7: irq_o is high in the cycle after any cycle in which bit 15 or bit 16 is set, and low in the cycle after both are clear.
- R8: tx_done_i sets bit 0 only when tx_ioc_i is high in the same cycle. Otherwise it has no effect.
- R9: Bits 19:17 read rx_state_i. Bits 22:20 read 3'b011 while tx_run_i is high and 3'b000 otherwise. Both fields follow their inputs without delay.
- R10: While rst_ni is low, all flags and both summaries are 0 and irq_o is 0.
- R11: In a cycle with no set pulse and no write, no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data; a 1 clears the matching flag |
| reg_rdata_o | output | 32 | Status word readback |
| tx_done_i | input | 1 | Transmit completion pulse |
| tx_ioc_i | input | 1 | Interrupt-on-completion bit of the completing descriptor |
| tx_stop_i | input | 1 | Transmit process stopped pulse |
| tx_nobuf_i | input | 1 | Transmit buffer unavailable pulse |
| tx_jabber_i | input | 1 | Transmit jabber timeout pulse |
| tx_underflow_i | input | 1 | Transmit underflow pulse |
| rx_done_i | input | 1 | Receive completion pulse |
| rx_nobuf_i | input | 1 | Receive buffer unavailable pulse |
| rx_stop_i | input | 1 | Receive process stopped pulse |
| rx_wdog_i | input | 1 | Receive watchdog timeout pulse |
| timer_i | input | 1 | General timer expiry pulse |
| bus_err_i | input | 1 | Fatal bus error pulse |
| tx_run_i | input | 1 | Transmit process running |
| rx_state_i | input | 3 | Receive process state code |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives a set pulse and a clear of the same flag in one cycle. A design where the clear wins would drop that event. It clears flags one group at a time, so that one summary must fall while the other stays up. A design that keeps a stale summary, or keeps the line high once both summaries are clear, shows a wrong bit 15 or 16 or a late irq_o. It writes all ones with no events pending, to catch a summary bit or an undefined bit that latches write data. It pulses tx_done_i with tx_ioc_i low, where an ungated design would set bit 0 and raise the interrupt.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EVT_N  = 11;

  // event index -> status bit position
  localparam int unsigned EVT_POS [EVT_N] = '{0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13};
  localparam int unsigned EVT_NORM [EVT_N] = '{1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0};

  localparam int unsigned ABN_BIT   = 15;
  localparam int unsigned NORM_BIT  = 16;
  localparam int unsigned RXST_LSB  = 17;
  localparam int unsigned TXST_LSB  = 20;
  localparam int unsigned ST_W      = 3;
  localparam logic [ST_W-1:0] TX_RUN_CODE = 3'b011;

  function automatic logic [DATA_W-1:0] grp_mask(input logic want_norm, input logic want_abn);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < EVT_N; i++) begin
      if ((EVT_NORM[i] == 1 && want_norm) || (EVT_NORM[i] == 0 && want_abn))
        m[EVT_POS[i]] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] NORM_MASK = grp_mask(1'b1, 1'b0);
  localparam logic [DATA_W-1:0] ABN_MASK  = grp_mask(1'b0, 1'b1);
  localparam logic [DATA_W-1:0] FLAG_MASK = NORM_MASK | ABN_MASK;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  // set dominates clear so a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= ((flags_q & ~clr_i) | set_i) & VALID;
  end

  assign flags_o = flags_q;

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i & VALID)) == $past(set_i & VALID)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] NORM = '0,
  parameter logic [W-1:0] ABN  = '0
) (
  input  logic [W-1:0] flags_i,
  output logic         norm_o,
  output logic         abn_o
);
  // recomputed from the live flags only; no stored summary state
  assign norm_o = |(flags_i & NORM);
  assign abn_o  = |(flags_i & ABN);
endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= req_i;
  end

  assign irq_o = irq_q;

  assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> irq_o);
  assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !irq_o);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tx_done_i,
  input  logic              tx_ioc_i,
  input  logic              tx_stop_i,
  input  logic              tx_nobuf_i,
  input  logic              tx_jabber_i,
  input  logic              tx_underflow_i,
  input  logic              rx_done_i,
  input  logic              rx_nobuf_i,
  input  logic              rx_stop_i,
  input  logic              rx_wdog_i,
  input  logic              timer_i,
  input  logic              bus_err_i,
  input  logic              tx_run_i,
  input  logic [ST_W-1:0]   rx_state_i,
  output logic              irq_o
);
  logic [EVT_N-1:0]  evt;
  logic [DATA_W-1:0] set_vec, clr_vec, flags;
  logic              norm, abn;

  assign evt = {bus_err_i, timer_i, rx_wdog_i, rx_stop_i, rx_nobuf_i, rx_done_i,
                tx_underflow_i, tx_jabber_i, tx_nobuf_i, tx_stop_i,
                tx_done_i & tx_ioc_i};

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < EVT_N; i++) set_vec[EVT_POS[i]] = evt[i];
  end

  assign clr_vec = reg_wr_i ? reg_wdata_i : '0;

  irq_flag_bank #(.W(DATA_W), .VALID(FLAG_MASK)) u_flags (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags)
  );

  irq_summary #(.W(DATA_W), .NORM(NORM_MASK), .ABN(ABN_MASK)) u_sum (
    .flags_i(flags), .norm_o(norm), .abn_o(abn)
  );

  irq_line_reg u_line (
    .clk_i, .rst_ni, .req_i(norm | abn), .irq_o
  );

  always_comb begin
    reg_rdata_o = flags;
    reg_rdata_o[NORM_BIT] = norm;
    reg_rdata_o[ABN_BIT]  = abn;
    reg_rdata_o[RXST_LSB +: ST_W] = rx_state_i;
    reg_rdata_o[TXST_LSB +: ST_W] = tx_run_i ? TX_RUN_CODE : '0;
  end

  assert_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !tx_ioc_i && !flags[0]) |=> !reg_rdata_o[0]);

  assert_undef_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~(FLAG_MASK | (DATA_W'(1) << ABN_BIT) | (DATA_W'(1) << NORM_BIT)
                     | (DATA_W'(63) << RXST_LSB))) == '0);
endmodule

// File: tb/irq_status_reg_tb_top.sv
module irq_status_reg_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, rdata;
  logic tx_ioc = 1'b0, tx_run = 1'b0, irq;
  logic [2:0] rx_state = '0;
  logic [10:0] ev = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  int unsigned m_flags = 0;
  bit m_irq = 0;
  int unsigned lfsr = 32'h1ACE5;

  localparam int unsigned NORM_M = 32'h0000_0045;
  localparam int unsigned ABN_M  = 32'h0000_2BAA;
  int unsigned posmap [11] = '{0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13};

  always #2.5 clk = ~clk;

  irq_status_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .tx_done_i(ev[0]), .tx_ioc_i(tx_ioc), .tx_stop_i(ev[1]),
    .tx_nobuf_i(ev[2]), .tx_jabber_i(ev[3]), .tx_underflow_i(ev[4]),
    .rx_done_i(ev[5]), .rx_nobuf_i(ev[6]), .rx_stop_i(ev[7]), .rx_wdog_i(ev[8]),
    .timer_i(ev[9]), .bus_err_i(ev[10]), .tx_run_i(tx_run), .rx_state_i(rx_state),
    .irq_o(irq)
  );

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int unsigned exp_word();
    int unsigned w;
    w = m_flags;
    if ((m_flags & NORM_M) != 0) w |= 32'h1_0000;
    if ((m_flags & ABN_M) != 0)  w |= 32'h8000;
    w |= 32'(rx_state) << 17;
    if (tx_run) w |= 32'h3 << 20;
    return w;
  endfunction

  // called at a negedge; applies stimulus for one clock and compares
  task automatic step(input logic [10:0] e, input logic ioc, input logic wr,
                      input int unsigned wd);
    int unsigned setm, clrm;
    ev = e; tx_ioc = ioc; reg_wr = wr; reg_wdata = wd;
    setm = 0;
    for (int i = 0; i < 11; i++)
      if (e[i] && (i != 0 || ioc)) setm |= 32'd1 << posmap[i];
    clrm = wr ? wd : 0;
    m_irq = ((m_flags & (NORM_M | ABN_M)) != 0);
    m_flags = ((m_flags & ~clrm) | setm) & (NORM_M | ABN_M);
    @(posedge clk);
    @(negedge clk);
    ev = '0; tx_ioc = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R1/R4/R6/R8 flags", rdata & 32'h7FFF, m_flags);
    chk("R2 normal summary", rdata[16], exp_word() >> 16 & 1);
    chk("R3 abnormal summary", rdata[15], exp_word() >> 15 & 1);
    chk("R5/R9 full word", rdata, exp_word());
    chk("R7 irq", irq, m_irq);
  endtask

  task automatic idle();
    step('0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #(5 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset word", rdata, 0);
    chk("R10 reset irq", irq, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 each event alone, then clear it
    for (int i = 0; i < 11; i++) begin
      step(11'(1) << i, 1'b1, 1'b0, 0);
      idle();                                   // R7 irq visible, R11 hold
      step('0, 1'b0, 1'b1, 32'hFFFF_FFFF);
      idle();
    end
    // R8 tx_done without ioc
    step(11'h001, 1'b0, 1'b0, 0);
    idle();
    // R2/R3 both groups, then drop one group at a time
    step(11'h021, 1'b1, 1'b0, 0);
    step(11'h402, 1'b0, 1'b0, 0);
    idle();
    step('0, 1'b0, 1'b1, 32'h0000_0001);        // R4 partial clear
    step('0, 1'b0, 1'b1, 32'h0000_0040);        // normal summary falls
    idle();
    step('0, 1'b0, 1'b1, 32'h0001_8000);        // R5 summaries ignore writes
    step('0, 1'b0, 1'b1, 32'h0000_2002);        // abnormal summary falls
    idle();
    // R6 set and clear same flag together
    step(11'h080, 1'b0, 1'b1, 32'h0000_0100);
    idle();
    step('0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    idle();
    // R9 readback fields
    tx_run = 1'b1; rx_state = 3'd5;
    idle();
    tx_run = 1'b0; rx_state = 3'd2;
    idle();
    rx_state = 3'd0;
    // pseudo-random mix
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      step(11'(lfsr >> 5) & 11'(lfsr >> 17), lfsr[3], lfsr[9] & lfsr[10],
           lfsr ^ (lfsr << 7));
      tx_run = lfsr[20];
      rx_state = 3'(lfsr >> 24);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule